// File: doc/BRIEF.md
# Status-Polled Flash Bank Program/Erase Sequencer

This block runs whole-bank maintenance on a byte-wide parallel flash that takes commands through writes and reports progress through a status byte. A single start pulse selects one of two jobs on one bank. Erase wipes the bank. Program writes every byte of the bank in ascending offset order from a byte stream. After each command that starts an internal flash operation, the block polls the device status until the ready bit shows or a poll budget runs out. It then clears the status, returns the device to array-read mode and reads the whole bank back to confirm the job.

The program data arrives on a valid/ready byte stream. `src_ready` is high only while the sequencer is waiting for a byte, and a byte moves on any rising edge where both `src_valid` and `src_ready` are high. A low `src_valid` stalls the sequencer indefinitely without harm. A program job takes the bank's bytes twice, in the same order: once to write them and once to check the read-back. The source must therefore be able to replay the bank image. On a poll timeout the job ends early, and the source discards whatever it has not yet delivered.

The flash bus is simple. One strobe (write or read) is active per cycle. Read data is expected on `fl_rdata` in the cycle after `fl_re` and must be held until the next read. Bank `b` starts at address `b * BANK_BYTES`.

Top module: `flash_bank_sequencer`

## Requirements
- R1: A start is taken only while `busy` is low. The operation (`op_program`: 1 = program, 0 = erase) and `bank_sel` are latched at that edge. `busy` stays high until the cycle after `done`. A start pulse while busy has no effect on the job in progress and starts no second job.
- R2: An erase writes 0x20 and then 0xD0, both to the bank base address. The 0x20 write comes in the cycle after the start.
- R3: A program job handles offsets 0 to BANK_BYTES-1 in order. For each offset it writes 0x40 to base+offset (in the cycle after the start for offset 0), then the stream byte to base+offset. At least SETUP_GAP+1 cycles separate the two writes.
- R4: After the erase confirm and after each program data byte, the block writes 0x70 to the base and reads the base. A status byte with bit 7 set ends the poll. The attempt count restarts for every command, so each command may need up to POLL_LIMIT reads.
- R5: If POLL_LIMIT status reads in a row show bit 7 clear, the job times out. No further bytes are written, the read-back is skipped, and the result is 01.
- R6: Once polling ends, whether by ready or by timeout, the block writes 0x50 and then 0xFF to the base in consecutive cycles.
- R7: Read-back covers offsets 0 to BANK_BYTES-1 in order. After an erase, every byte must equal 0xFF. After a program, every byte must equal the replayed stream byte. Any difference gives result 10.
- R8: A ready status byte with any of bits 5..3 set (mask 0x38) gives result 11. This code wins over 10, and 01 wins over both. A clean job gives 00.
- R9: `src_ready` is high only while busy and only while a byte is needed. A program job that finishes its read-back takes exactly 2*BANK_BYTES stream bytes.
- R10: `done` is a one-cycle pulse at the end of each job. `result` is valid with it and holds until the next accepted start.
- R11: `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | start pulse, taken when idle |
| op_program | input | 1 | 1 = program the bank, 0 = erase it |
| bank_sel | input | BSEL_W | bank index |
| busy | output | 1 | job in progress |
| done | output | 1 | one-cycle end-of-job pulse |
| result | output | 2 | 00 ok, 01 timeout, 10 read-back mismatch, 11 device error |
| src_valid | input | 1 | stream byte present |
| src_data | input | 8 | stream byte |
| src_ready | output | 1 | sequencer takes a byte this cycle |
| fl_addr | output | ADDR_W | flash byte address |
| fl_wdata | output | 8 | flash write byte |
| fl_we | output | 1 | flash write strobe |
| fl_re | output | 1 | flash read strobe |
| fl_rdata | input | 8 | flash read byte, valid the cycle after fl_re |

## Verification
The bound checker watches several properties on every cycle: the strobe exclusivity, the single-cycle `done`, the freezing of the latched job while busy, the bound on the poll attempt counter, stream readiness only while busy, and the first command written after a start. Only the bench's flash model can show the longer behaviour. That includes the order of addresses across a whole bank, the setup-to-data spacing, the clear/reset tail after a timeout, the per-command restart of the poll budget, the skipped read-back, the priority of result codes, and the exact number of replayed stream bytes.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam logic [7:0] CMD_ERASE_ARM = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO  = 8'hD0;
  localparam logic [7:0] CMD_PROG_ARM  = 8'h40;
  localparam logic [7:0] CMD_STAT_RD   = 8'h70;
  localparam logic [7:0] CMD_STAT_CLR  = 8'h50;
  localparam logic [7:0] CMD_ARRAY     = 8'hFF;
  localparam logic [7:0] ERASED_VAL    = 8'hFF;
  localparam logic [7:0] STAT_ERR_MASK = 8'h38;
  localparam int         STAT_READY_BIT = 7;

  typedef enum logic [1:0] {
    RES_OK       = 2'b00,
    RES_TIMEOUT  = 2'b01,
    RES_MISMATCH = 2'b10,
    RES_DEVERR   = 2'b11
  } fbs_result_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ESETUP, S_ECONF, S_PSETUP, S_PGAP, S_PDATA,
    S_QCMD, S_QRD, S_QEVAL, S_CLR, S_RST, S_VRD, S_VCAP, S_VCMP, S_FIN
  } fbs_state_e;

  function automatic fbs_result_e fbs_pick(input logic tmo, input logic serr, input logic mism);
    if (tmo)       return RES_TIMEOUT;
    else if (serr) return RES_DEVERR;
    else if (mism) return RES_MISMATCH;
    else           return RES_OK;
  endfunction
endpackage

// File: rtl/fbs_gap_timer.sv
module fbs_gap_timer #(
  parameter int GAP = 125,
  localparam int GW = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [GW-1:0] cnt_q;

  assign expired = run && (cnt_q == GW'(GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + GW'(1);
  end
endmodule

// File: rtl/fbs_poll_counter.sv
module fbs_poll_counter #(
  parameter int LIMIT = 1000000,
  localparam int CW = $clog2(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bump,
  output logic          last_try,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q;

  assign count    = cnt_q;
  assign last_try = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (bump) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/fbs_offset_walker.sv
module fbs_offset_walker #(
  parameter int BYTES = 8192,
  localparam int OW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [OW-1:0] ofs,
  output logic          at_last
);
  logic [OW-1:0] ofs_q;

  assign ofs     = ofs_q;
  assign at_last = (ofs_q == OW'(BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ofs_q <= '0;
    else if (clr)  ofs_q <= '0;
    else if (step) ofs_q <= ofs_q + OW'(1);
  end
endmodule

// File: rtl/fbs_outcome.sv
module fbs_outcome
  import fbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       set_tmo,
  input  logic       set_serr,
  input  logic       chk_en,
  input  logic [7:0] got,
  input  logic [7:0] want,
  output logic       timed_out,
  output logic [1:0] result
);
  logic tmo_q, serr_q, mism_q;

  assign timed_out = tmo_q;
  assign result    = fbs_pick(tmo_q, serr_q, mism_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= 1'b0;
      serr_q <= 1'b0;
      mism_q <= 1'b0;
    end else if (clr) begin
      tmo_q  <= 1'b0;
      serr_q <= 1'b0;
      mism_q <= 1'b0;
    end else begin
      if (set_tmo)                 tmo_q  <= 1'b1;
      if (set_serr)                serr_q <= 1'b1;
      if (chk_en && (got != want)) mism_q <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_bank_sequencer.sv
module flash_bank_sequencer
  import fbs_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 8192,
  parameter int POLL_LIMIT = 1000000,
  parameter int SETUP_GAP  = 125,
  localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W = $clog2(NUM_BANKS * BANK_BYTES),
  localparam int OFS_W  = $clog2(BANK_BYTES),
  localparam int PCNT_W = $clog2(POLL_LIMIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_program,
  input  logic [BSEL_W-1:0] bank_sel,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  input  logic              src_valid,
  input  logic [7:0]        src_data,
  output logic              src_ready,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata
);
  fbs_state_e        state, nxt;
  logic              op_q;
  logic [BSEL_W-1:0] bank_q;
  logic [7:0]        rd_q;

  logic [OFS_W-1:0]  ofs;
  logic              at_last, ofs_clr, ofs_step;
  logic              poll_clr, poll_bump, poll_last;
  logic [PCNT_W-1:0] poll_cnt;
  logic              gap_done;
  logic              flags_clr, set_tmo, set_serr, chk_en, timed_out;
  logic [7:0]        want;
  logic [ADDR_W-1:0] base_addr, byte_addr;

  assign base_addr = ADDR_W'(bank_q) * ADDR_W'(BANK_BYTES);
  assign byte_addr = base_addr + ADDR_W'(ofs);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign poll_clr  = !(state inside {S_QCMD, S_QRD, S_QEVAL});
  assign want      = op_q ? src_data : ERASED_VAL;

  fbs_offset_walker #(.BYTES(BANK_BYTES)) u_ofs (
    .clk(clk), .rst_n(rst_n), .clr(ofs_clr), .step(ofs_step),
    .ofs(ofs), .at_last(at_last)
  );

  fbs_poll_counter #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .bump(poll_bump),
    .last_try(poll_last), .count(poll_cnt)
  );

  fbs_gap_timer #(.GAP(SETUP_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(state == S_PGAP), .expired(gap_done)
  );

  fbs_outcome u_out (
    .clk(clk), .rst_n(rst_n), .clr(flags_clr), .set_tmo(set_tmo),
    .set_serr(set_serr), .chk_en(chk_en), .got(rd_q), .want(want),
    .timed_out(timed_out), .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= 1'b0;
      bank_q <= '0;
      rd_q   <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) begin
        op_q   <= op_program;
        bank_q <= bank_sel;
      end
      if (state == S_VCAP) rd_q <= fl_rdata;
    end
  end

  // sequencing
  always_comb begin
    nxt       = state;
    ofs_clr   = 1'b0;
    ofs_step  = 1'b0;
    poll_bump = 1'b0;
    set_tmo   = 1'b0;
    set_serr  = 1'b0;
    chk_en    = 1'b0;
    flags_clr = 1'b0;
    case (state)
      S_IDLE: begin
        ofs_clr = 1'b1;
        if (start) begin
          flags_clr = 1'b1;
          nxt = op_program ? S_PSETUP : S_ESETUP;
        end
      end
      S_ESETUP: nxt = S_ECONF;
      S_ECONF:  nxt = S_QCMD;
      S_PSETUP: nxt = S_PGAP;
      S_PGAP:   if (gap_done) nxt = S_PDATA;
      S_PDATA:  if (src_valid) nxt = S_QCMD;
      S_QCMD:   nxt = S_QRD;
      S_QRD:    nxt = S_QEVAL;
      S_QEVAL: begin
        if (fl_rdata[STAT_READY_BIT]) begin
          if ((fl_rdata & STAT_ERR_MASK) != 8'h00) set_serr = 1'b1;
          if (!op_q || at_last) nxt = S_CLR;
          else begin
            ofs_step = 1'b1;
            nxt = S_PSETUP;
          end
        end else if (poll_last) begin
          set_tmo = 1'b1;
          nxt = S_CLR;
        end else begin
          poll_bump = 1'b1;
          nxt = S_QCMD;
        end
      end
      S_CLR: nxt = S_RST;
      S_RST: begin
        ofs_clr = 1'b1;
        nxt = timed_out ? S_FIN : S_VRD;
      end
      S_VRD:  nxt = S_VCAP;
      S_VCAP: nxt = S_VCMP;
      S_VCMP: begin
        if (!op_q || src_valid) begin
          chk_en = 1'b1;
          if (at_last) nxt = S_FIN;
          else begin
            ofs_step = 1'b1;
            nxt = S_VRD;
          end
        end
      end
      S_FIN:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  // flash bus and stream drive
  always_comb begin
    fl_we     = 1'b0;
    fl_re     = 1'b0;
    fl_wdata  = CMD_ARRAY;
    fl_addr   = base_addr;
    src_ready = 1'b0;
    case (state)
      S_ESETUP: begin fl_we = 1'b1; fl_wdata = CMD_ERASE_ARM; end
      S_ECONF:  begin fl_we = 1'b1; fl_wdata = CMD_ERASE_GO;  end
      S_PSETUP: begin fl_we = 1'b1; fl_wdata = CMD_PROG_ARM; fl_addr = byte_addr; end
      S_PDATA: begin
        src_ready = 1'b1;
        fl_we     = src_valid;
        fl_wdata  = src_data;
        fl_addr   = byte_addr;
      end
      S_QCMD:  begin fl_we = 1'b1; fl_wdata = CMD_STAT_RD;  end
      S_QRD:   fl_re = 1'b1;
      S_CLR:   begin fl_we = 1'b1; fl_wdata = CMD_STAT_CLR; end
      S_RST:   begin fl_we = 1'b1; fl_wdata = CMD_ARRAY;    end
      S_VRD:   begin fl_re = 1'b1; fl_addr = byte_addr; end
      S_VCMP:  src_ready = op_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
  parameter int POLL_LIMIT = 1000000,
  parameter int PCNT_W = 20,
  parameter int BSEL_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              op_program,
  input logic              busy,
  input logic              done,
  input logic [1:0]        result,
  input logic              src_ready,
  input logic              fl_we,
  input logic              fl_re,
  input logic [7:0]        fl_wdata,
  input logic [PCNT_W-1:0] poll_cnt,
  input logic              op_q,
  input logic [BSEL_W-1:0] bank_q
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(result));

  // R1
  job_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(bank_q)));

  // R1
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  erase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op_program) |=> (fl_we && fl_wdata == 8'h20));

  // R3
  prog_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_program) |=> (fl_we && fl_wdata == 8'h40));

  // R4
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PCNT_W'(POLL_LIMIT));

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> busy);
endmodule

bind flash_bank_sequencer fbs_checker #(
  .POLL_LIMIT(POLL_LIMIT), .PCNT_W(PCNT_W), .BSEL_W(BSEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_program(op_program),
  .busy(busy), .done(done), .result(result), .src_ready(src_ready),
  .fl_we(fl_we), .fl_re(fl_re), .fl_wdata(fl_wdata), .poll_cnt(poll_cnt),
  .op_q(op_q), .bank_q(bank_q)
);

// File: tb/flash_bank_sequencer_test.sv
module flash_bank_sequencer_test;
  localparam int NB = 2, BB = 32, PL = 6, SG = 3, AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0, op_program = 1'b0;
  logic [0:0] bank_sel = 1'b0;
  logic busy, done, src_ready, fl_we, fl_re;
  logic [1:0] result;
  logic src_valid = 1'b0;
  logic [7:0] src_data = 8'h00, fl_wdata, fl_rdata = 8'h00;
  logic [AW-1:0] fl_addr;

  flash_bank_sequencer #(.NUM_BANKS(NB), .BANK_BYTES(BB), .POLL_LIMIT(PL), .SETUP_GAP(SG)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_program(op_program), .bank_sel(bank_sel),
    .busy(busy), .done(done), .result(result), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we),
    .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  int total = 0, bad = 0, cyc = 0;

  // flash model and stream source state
  logic [7:0] mem [0:NB*BB-1];
  logic [7:0] pat [0:BB-1];
  int  busy_left = 0, fixed_delay = -1, stuck_byte = -1, corrupt_off = -1, defect_off = -1;
  bit  status_mode = 0, prog_armed = 0, erase_armed = 0, err_inj = 0, stuck_erase = 0;
  int  wr_cnt, stat_rd, arr_rd, data_wr, viol, gap_bad, erase_cmds, setup_cyc, exp_ofs, op_bank;
  logic [7:0] w0, w1, wl1, wl2;
  logic [AW-1:0] a0, a1;
  bit  rand_valid = 0, src_en = 0, hs_pend = 0;
  int  idx = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  function automatic int pick_delay();
    if (fixed_delay >= 0) return fixed_delay;
    return int'($urandom % PL);
  endfunction

  task automatic model_write();
    int o = int'(fl_addr) % BB;
    int bk = int'(fl_addr) / BB;
    wr_cnt++;
    if (wr_cnt == 1) begin a0 = fl_addr; w0 = fl_wdata; end
    if (wr_cnt == 2) begin a1 = fl_addr; w1 = fl_wdata; end
    wl2 = wl1; wl1 = fl_wdata;
    if (bk != op_bank) viol++;
    if (prog_armed) begin
      prog_armed = 0;
      if (o != exp_ofs) viol++;
      if (cyc - setup_cyc < SG + 1) gap_bad++;
      mem[fl_addr] = (o == corrupt_off) ? (fl_wdata ^ 8'h01) : fl_wdata;
      busy_left = (data_wr == stuck_byte) ? 1000000 : pick_delay();
      data_wr++;
      exp_ofs++;
    end else begin
      case (fl_wdata)
        8'h40: begin prog_armed = 1; setup_cyc = cyc; if (o != exp_ofs) viol++; end
        8'h20: begin erase_armed = 1; erase_cmds++; if (o != 0) viol++; end
        8'hD0: begin
          if (!erase_armed || o != 0) viol++;
          for (int i = 0; i < BB; i++) mem[bk*BB+i] = (i == defect_off) ? 8'h00 : 8'hFF;
          busy_left = stuck_erase ? 1000000 : pick_delay();
          erase_armed = 0;
        end
        8'h70: begin status_mode = 1; if (o != 0) viol++; end
        8'h50: if (o != 0) viol++;
        8'hFF: begin status_mode = 0; if (o != 0) viol++; end
        default: viol++;
      endcase
    end
  endtask

  task automatic model_read();
    if (status_mode) begin
      stat_rd++;
      if (busy_left > 0) begin busy_left--; fl_rdata = 8'h00; end
      else fl_rdata = err_inj ? 8'h90 : 8'h80;
    end else begin
      arr_rd++;
      fl_rdata = mem[fl_addr];
    end
  endtask

  // inputs change at the falling edge; the model acts once they settle
  always @(negedge clk) begin
    if (hs_pend) idx++;
    src_valid = src_en && (rand_valid ? (($urandom % 3) != 0) : 1'b1);
    src_data  = pat[idx % BB];
    #1;
    hs_pend = src_valid && src_ready;
    if (fl_we) model_write();
    if (fl_re) model_read();
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int bank_diff(input int bk, input int kind, input logic [7:0] fillv);
    int n = 0;
    for (int i = 0; i < BB; i++) begin
      logic [7:0] e = (kind == 0) ? 8'hFF : (kind == 1) ? pat[i] : fillv;
      if (mem[bk*BB+i] !== e) n++;
    end
    return n;
  endfunction

  task automatic clear_faults();
    fixed_delay = -1; stuck_byte = -1; corrupt_off = -1; defect_off = -1;
    err_inj = 0; stuck_erase = 0; rand_valid = 0;
  endtask

  task automatic run_op(input bit op, input int bank, input bit poke, output logic [1:0] res);
    int n = 0;
    wr_cnt = 0; stat_rd = 0; arr_rd = 0; data_wr = 0; viol = 0; gap_bad = 0;
    erase_cmds = 0; exp_ofs = 0; op_bank = bank; idx = 0; hs_pend = 0; src_en = op;
    @(negedge clk);
    start = 1'b1; op_program = op; bank_sel = bank[0:0];
    do begin
      @(negedge clk);
      n++;
      start = poke && (n == 50);
      if (start) begin op_program = 1'b0; bank_sel = ~bank[0:0]; end
      #2;
    end while (!done && n < 20000);
    check(done, "R1 job completes", n, 0);
    res = result;
    @(negedge clk); #2;
    chk_eq("R10 done single cycle", done, 0);
    chk_eq("R10 result held", result, res);
    chk_eq("R1 busy released", busy, 0);
    src_en = 0;
  endtask

  initial begin
    logic [1:0] r;
    int unsigned sd;
    sd = $urandom(32'd9127);
    for (int i = 0; i < NB*BB; i++) mem[i] = 8'h5A;
    for (int i = 0; i < BB; i++) pat[i] = 8'h00;
    repeat (3) @(negedge clk);
    #2;
    chk_eq("R10 reset busy", busy, 0);
    chk_eq("R10 reset done", done, 0);
    chk_eq("R11 reset strobes", {fl_we, fl_re}, 0);
    chk_eq("R9 reset ready", src_ready, 0);
    chk_eq("R10 reset result", result, 0);
    rst_n = 1'b1;

    // directed erase, bank 1, two busy polls
    clear_faults(); fixed_delay = 2;
    run_op(1'b0, 1, 1'b0, r);
    chk_eq("R2 erase ok", r, 0);
    chk_eq("R2 first write addr", a0, BB);
    chk_eq("R2 first write 0x20", w0, 8'h20);
    chk_eq("R2 second write 0xD0", w1, 8'hD0);
    chk_eq("R4 status reads", stat_rd, 3);
    chk_eq("R6 tail clear", wl2, 8'h50);
    chk_eq("R6 tail reset", wl1, 8'hFF);
    chk_eq("R7 read-back count", arr_rd, BB);
    chk_eq("R2 bank erased", bank_diff(1, 0, 0), 0);
    chk_eq("R2 other bank kept", bank_diff(0, 2, 8'h5A), 0);
    chk_eq("R4 protocol", viol, 0);

    // random programs
    for (int k = 0; k < 6; k++) begin
      int b = int'($urandom % NB);
      clear_faults(); rand_valid = 1;
      for (int i = 0; i < BB; i++) pat[i] = 8'($urandom);
      run_op(1'b1, b, 1'b0, r);
      chk_eq("R3 program ok", r, 0);
      chk_eq("R3 content", bank_diff(b, 1, 0), 0);
      chk_eq("R3 data writes", data_wr, BB);
      chk_eq("R3 order/address", viol, 0);
      chk_eq("R3 setup gap", gap_bad, 0);
      chk_eq("R9 stream bytes", idx, 2*BB);
      chk_eq("R7 read-back count", arr_rd, BB);
    end

    // every command needs the full poll budget
    clear_faults(); fixed_delay = PL - 1;
    for (int i = 0; i < BB; i++) pat[i] = 8'(i * 7 + 3);
    run_op(1'b1, 0, 1'b0, r);
    chk_eq("R4 budget per command", r, 0);
    chk_eq("R4 status reads", stat_rd, BB*PL);

    // erase never ready
    clear_faults(); stuck_erase = 1;
    run_op(1'b0, 0, 1'b0, r);
    chk_eq("R5 erase timeout", r, 1);
    chk_eq("R5 poll reads", stat_rd, PL);
    chk_eq("R5 no read-back", arr_rd, 0);
    chk_eq("R6 tail clear", wl2, 8'h50);
    chk_eq("R6 tail reset", wl1, 8'hFF);

    // program stalls at byte 3
    clear_faults(); stuck_byte = 3; rand_valid = 1;
    run_op(1'b1, 1, 1'b0, r);
    chk_eq("R5 program timeout", r, 1);
    chk_eq("R5 writes stop", data_wr, 4);
    chk_eq("R5 stream stop", idx, 4);
    chk_eq("R5 no read-back", arr_rd, 0);
    chk_eq("R6 tail reset", wl1, 8'hFF);

    // read-back mismatch
    clear_faults(); corrupt_off = 5;
    run_op(1'b1, 0, 1'b0, r);
    chk_eq("R7 program mismatch", r, 2);
    clear_faults(); defect_off = BB - 1;
    run_op(1'b0, 1, 1'b0, r);
    chk_eq("R7 erase mismatch last byte", r, 2);

    // device error bits
    clear_faults(); err_inj = 1;
    run_op(1'b1, 1, 1'b0, r);
    chk_eq("R8 device error", r, 3);
    clear_faults(); err_inj = 1; corrupt_off = 0;
    run_op(1'b1, 1, 1'b0, r);
    chk_eq("R8 error beats mismatch", r, 3);
    clear_faults();
    run_op(1'b1, 1, 1'b0, r);
    chk_eq("R8 clean after error", r, 0);

    // start while busy is ignored
    clear_faults();
    for (int i = 0; i < BB; i++) mem[BB+i] = 8'h33;
    for (int i = 0; i < BB; i++) pat[i] = 8'(8'hC0 ^ i);
    run_op(1'b1, 0, 1'b1, r);
    chk_eq("R1 job unaffected", r, 0);
    chk_eq("R1 no erase issued", erase_cmds, 0);
    chk_eq("R1 other bank kept", bank_diff(1, 2, 8'h33), 0);
    chk_eq("R1 content", bank_diff(0, 1, 0), 0);
    @(negedge clk); #2;
    chk_eq("R1 stays idle", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule